// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block keeps track of pending interrupt vectors for one processor core and offers the core one vector at a time. It has 256 vectors and holds three bit-per-vector maps: a request map, an in-service map and a trigger-mode map. A fixed-mode request port sets bits in the request map. The core acknowledges the offered vector, which moves that vector from requested to in service. An end-of-interrupt strobe retires the highest vector in service. When the retired vector was level-triggered, the block sends a one-cycle notice carrying that vector onward, unless the notice is suppressed.

Delivery is gated by a derived priority built from two inputs: a software-written task priority and the 4-bit class of the highest vector in service. A vector is offered only if its class lies strictly above that derived priority. Vectors of class 0 are therefore never offered. A 32-bit summary word packs the task priority, the class of the highest vector in service and the highest requested vector, so one read gives a quick snapshot.

Top module: `irq_prio_ctrl`

## Requirements
- R1: With both enables high, a request (`req_valid`) for a vector whose request bit is clear raises `req_accepted` in the same cycle. At the next edge the block sets that request bit. It also writes that vector's trigger-mode bit to `req_level` (1 = level, 0 = edge).
- R2: A request for a vector whose request bit is already set gives `req_accepted` low and changes no state.
- R3: While `hw_en` or `sw_en` is low, requests are dropped: `req_accepted` stays low and the request map does not change.
- R4: `ppr` equals the task priority when bits 7:4 of the task priority are at least the class (bits 7:4) of the highest in-service vector. Otherwise `ppr` is that vector with bits 3:0 cleared. An empty in-service map counts as vector 0.
- R5: `irq_pending` is high, and `irq_vector` holds the highest requested vector, exactly when the request map is non-empty and that vector's bits 7:4 are strictly greater than `ppr` bits 7:4. Both outputs are registered and follow the state of the previous cycle.
- R6: `irq_ack`, in a cycle where the current state makes a vector deliverable, sets the in-service bit of the highest requested vector and clears its request bit. In any other cycle `irq_ack` has no effect.
- R7: `eoi` clears the highest in-service bit, and the priority is then recomputed. With an empty in-service map, `eoi` has no effect.
- R8: When `eoi` retires a vector whose trigger-mode bit is set, that bit is cleared. In the next cycle `level_eoi_valid` is high for exactly one cycle, with the vector on `level_eoi_vector`, provided `eoi_bcast_suppress` was low. Otherwise no pulse is produced.
- R9: A task-priority write (`tpr_we`) keeps only `tpr_wdata[7:0]`, and `tpr_rdata` shows it from the next cycle on.
- R10: `summary` carries the task priority in bits 7:0, the class of the highest in-service vector in bits 15:12 and the highest requested vector in bits 31:24. All other bits are 0, and a field belonging to an empty map reads 0.
- R11: After reset, the task priority and all three maps are zero, and `irq_pending` and `level_eoi_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hw_en | input | 1 | Hardware enable for request intake |
| sw_en | input | 1 | Software enable for request intake |
| eoi_bcast_suppress | input | 1 | Blocks the level end-of-interrupt notice |
| req_valid | input | 1 | Fixed-mode request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| req_accepted | output | 1 | The request in this cycle is taken |
| irq_ack | input | 1 | Core acknowledge of the offered vector |
| irq_pending | output | 1 | A deliverable vector exists (registered) |
| irq_vector | output | 8 | Vector offered to the core (registered) |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 32 | Task-priority write data |
| tpr_rdata | output | 8 | Current task priority |
| ppr | output | 8 | Derived processor priority |
| eoi | input | 1 | End-of-interrupt strobe |
| level_eoi_valid | output | 1 | One-cycle notice for a retired level vector |
| level_eoi_vector | output | 8 | Vector of that notice |
| summary | output | 32 | Packed priority snapshot |

## Verification
The bench sweeps every vector as an edge request and as a level request. This shows whether class-0 vectors are wrongly offered, and whether an encoder slip at a group boundary picks the wrong vector. A repeated request to the same vector must come back as not accepted. Every task priority value is tried against one pending vector. A design that compared with greater-or-equal, or used the full byte instead of the class, would offer or hold the wrong vectors. Nested in-service vectors check that end-of-interrupt retires the highest vector first, and that a lower vector stays blocked until the higher ones are gone. Runs with the suppress control set check that no notice leaks out. An end-of-interrupt with nothing in service, and an acknowledge with nothing deliverable, must leave the summary unchanged.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int VEC_W   = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam int CLASS_W = 4;
  localparam int SUM_W   = 32;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int WIDTH   = 256,
  parameter int GROUP_W = 32
) (
  input  logic [WIDTH-1:0]         bits_i,
  output logic                     found_o,
  output logic [$clog2(WIDTH)-1:0] index_o
);
  localparam int IDX_W = $clog2(WIDTH);
  localparam int LOC_W = $clog2(GROUP_W);
  localparam int NGRP  = WIDTH / GROUP_W;
  localparam int GRP_W = IDX_W - LOC_W;

  logic [NGRP-1:0]       grp_any;
  logic [NGRP*LOC_W-1:0] grp_idx_flat;

  // first level: highest set bit inside each group
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP_W-1:0] slice;
    logic [LOC_W-1:0]   loc_idx;
    assign slice = bits_i[g*GROUP_W +: GROUP_W];
    always_comb begin
      loc_idx = '0;
      for (int b = 0; b < GROUP_W; b++) begin
        if (slice[b]) loc_idx = LOC_W'(b);
      end
    end
    assign grp_any[g] = |slice;
    assign grp_idx_flat[g*LOC_W +: LOC_W] = loc_idx;
  end

  // second level: highest non-empty group
  always_comb begin
    found_o = |grp_any;
    index_o = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_any[g]) index_o = {GRP_W'(g), grp_idx_flat[g*LOC_W +: LOC_W]};
    end
  end
endmodule

// File: rtl/irq_vec_bitmaps.sv
module irq_vec_bitmaps
  import irq_prio_pkg::*;
#(
  parameter int NUM = NUM_VEC
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_en,
  input  vec_t           req_vec,
  input  logic           req_level,
  input  logic           ack_en,
  input  vec_t           ack_vec,
  input  logic           eoi_en,
  input  vec_t           eoi_vec,
  output logic [NUM-1:0] irr_o,
  output logic [NUM-1:0] isr_o,
  output logic [NUM-1:0] tmr_o
);
  logic [NUM-1:0] irr_q, isr_q, tmr_q;
  logic [NUM-1:0] irr_d, isr_d, tmr_d;
  logic           upd_en;

  assign upd_en = req_en | ack_en | eoi_en;

  // merge order: acknowledge, then retire, then a new request
  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_en) begin
      isr_d[ack_vec] = 1'b1;
      irr_d[ack_vec] = 1'b0;
    end
    if (eoi_en) begin
      isr_d[eoi_vec] = 1'b0;
      tmr_d[eoi_vec] = 1'b0;
    end
    if (req_en) begin
      tmr_d[req_vec] = req_level;
      irr_d[req_vec] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else if (upd_en) begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
  assign tmr_o = tmr_q;
endmodule

// File: rtl/irq_prio_calc.sv
module irq_prio_calc
  import irq_prio_pkg::*;
(
  input  vec_t tpr_i,
  input  logic isr_found_i,
  input  vec_t isr_top_i,
  input  logic irr_found_i,
  input  vec_t irr_top_i,
  output vec_t ppr_o,
  output logic deliver_o
);
  localparam int CL_HI = VEC_W - 1;
  localparam int CL_LO = VEC_W - CLASS_W;

  vec_t isr_eff;
  assign isr_eff = isr_found_i ? isr_top_i : '0;

  always_comb begin
    if (tpr_i[CL_HI:CL_LO] >= isr_eff[CL_HI:CL_LO]) ppr_o = tpr_i;
    else ppr_o = {isr_eff[CL_HI:CL_LO], {CL_LO{1'b0}}};
    deliver_o = irr_found_i && (irr_top_i[CL_HI:CL_LO] > ppr_o[CL_HI:CL_LO]);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int GROUP_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hw_en,
  input  logic        sw_en,
  input  logic        eoi_bcast_suppress,
  input  logic        req_valid,
  input  logic [7:0]  req_vector,
  input  logic        req_level,
  output logic        req_accepted,
  input  logic        irq_ack,
  output logic        irq_pending,
  output logic [7:0]  irq_vector,
  input  logic        tpr_we,
  input  logic [31:0] tpr_wdata,
  output logic [7:0]  tpr_rdata,
  output logic [7:0]  ppr,
  input  logic        eoi,
  output logic        level_eoi_valid,
  output logic [7:0]  level_eoi_vector,
  output logic [31:0] summary
);
  localparam int CL_LO = VEC_W - CLASS_W;

  logic [NUM_VEC-1:0] irr, isr, tmr;
  logic irr_found, isr_found, deliver_now;
  vec_t irr_top, isr_top, ppr_now;
  logic ack_fire, eoi_fire, eoi_is_level;

  vec_t tpr_q, tpr_d;
  logic pend_q, pend_d;
  vec_t pvec_q, pvec_d;
  logic leoi_q, leoi_d;
  vec_t leoi_vec_q, leoi_vec_d;

  irq_msb_find #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) u_irr_top (
    .bits_i(irr), .found_o(irr_found), .index_o(irr_top));
  irq_msb_find #(.WIDTH(NUM_VEC), .GROUP_W(GROUP_W)) u_isr_top (
    .bits_i(isr), .found_o(isr_found), .index_o(isr_top));

  irq_prio_calc u_calc (
    .tpr_i(tpr_q), .isr_found_i(isr_found), .isr_top_i(isr_top),
    .irr_found_i(irr_found), .irr_top_i(irr_top),
    .ppr_o(ppr_now), .deliver_o(deliver_now));

  assign req_accepted = req_valid & hw_en & sw_en & ~irr[req_vector];
  assign ack_fire     = irq_ack & deliver_now;
  assign eoi_fire     = eoi & isr_found;
  assign eoi_is_level = tmr[isr_top];

  irq_vec_bitmaps #(.NUM(NUM_VEC)) u_maps (
    .clk(clk), .rst_n(rst_n),
    .req_en(req_accepted), .req_vec(req_vector), .req_level(req_level),
    .ack_en(ack_fire), .ack_vec(irr_top),
    .eoi_en(eoi_fire), .eoi_vec(isr_top),
    .irr_o(irr), .isr_o(isr), .tmr_o(tmr));

  always_comb begin
    tpr_d      = tpr_we ? tpr_wdata[VEC_W-1:0] : tpr_q;
    pend_d     = deliver_now;
    pvec_d     = deliver_now ? irr_top : '0;
    leoi_d     = eoi_fire & eoi_is_level & ~eoi_bcast_suppress;
    leoi_vec_d = leoi_d ? isr_top : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q      <= '0;
      pend_q     <= 1'b0;
      pvec_q     <= '0;
      leoi_q     <= 1'b0;
      leoi_vec_q <= '0;
    end else begin
      if (tpr_we) tpr_q <= tpr_d;
      pend_q     <= pend_d;
      pvec_q     <= pvec_d;
      leoi_q     <= leoi_d;
      leoi_vec_q <= leoi_vec_d;
    end
  end

  assign irq_pending      = pend_q;
  assign irq_vector       = pvec_q;
  assign tpr_rdata        = tpr_q;
  assign ppr              = ppr_now;
  assign level_eoi_valid  = leoi_q;
  assign level_eoi_vector = leoi_vec_q;
  assign summary = {(irr_found ? irr_top : 8'h00), 8'h00,
                    (isr_found ? isr_top[VEC_W-1:CL_LO] : 4'h0), 4'h0, tpr_q};
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hw_en,
  input logic        sw_en,
  input logic        eoi_bcast_suppress,
  input logic        req_valid,
  input logic [7:0]  req_vector,
  input logic        req_level,
  input logic        req_accepted,
  input logic        irq_ack,
  input logic        irq_pending,
  input logic [7:0]  irq_vector,
  input logic        tpr_we,
  input logic [31:0] tpr_wdata,
  input logic [7:0]  tpr_rdata,
  input logic [7:0]  ppr,
  input logic        eoi,
  input logic        level_eoi_valid,
  input logic [7:0]  level_eoi_vector,
  input logic [31:0] summary
);
  AST_ACCEPT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_accepted |-> req_valid); // R1
  AST_DROP_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_en || !sw_en) |-> !req_accepted); // R3
  AST_PPR_NOT_BELOW_TPR: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_rdata); // R4
  AST_PENDING_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (irq_vector[7:4] > $past(ppr[7:4]))); // R5
  AST_LEOI_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    level_eoi_valid |-> $past(eoi)); // R8
  AST_LEOI_NOT_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    level_eoi_valid |-> !$past(eoi_bcast_suppress)); // R8
  AST_TPR_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    tpr_we |=> (tpr_rdata == $past(tpr_wdata[7:0]))); // R9
  AST_SUMMARY_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (summary[23:16] == 8'h00) && (summary[11:8] == 4'h0)); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (.*);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic hw_en, sw_en, eoi_bcast_suppress;
  logic req_valid, req_level, req_accepted;
  logic [7:0] req_vector;
  logic irq_ack, irq_pending;
  logic [7:0] irq_vector;
  logic tpr_we;
  logic [31:0] tpr_wdata;
  logic [7:0] tpr_rdata, ppr;
  logic eoi, level_eoi_valid;
  logic [7:0] level_eoi_vector;
  logic [31:0] summary;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state built from the requirements
  logic [255:0] m_irr, m_isr, m_tmr;
  logic [7:0]   m_tpr;

  always #2 clk = ~clk;

  irq_prio_ctrl u0 (.*);

  function automatic int top_of(logic [255:0] b);
    int r = -1;
    for (int i = 0; i < 256; i++) if (b[i]) r = i;
    return r;
  endfunction

  function automatic logic [7:0] m_ppr();
    int t = top_of(m_isr);
    logic [7:0] iv = (t < 0) ? 8'h00 : 8'(t);
    return (m_tpr[7:4] >= iv[7:4]) ? m_tpr : {iv[7:4], 4'h0};
  endfunction

  function automatic logic m_deliver();
    int t = top_of(m_irr);
    logic [7:0] p = m_ppr();
    logic [7:0] tv = 8'(t);
    return (t >= 0) && (tv[7:4] > p[7:4]);
  endfunction

  function automatic logic [31:0] m_summary();
    int ti = top_of(m_irr);
    int ts = top_of(m_isr);
    logic [7:0] iv = (ti < 0) ? 8'h00 : 8'(ti);
    logic [7:0] sv = (ts < 0) ? 8'h00 : 8'(ts);
    return {iv, 8'h00, sv[7:4], 4'h0, m_tpr};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(string req);
    chk({req, "/R5 pending"}, 32'(irq_pending), 32'(m_deliver()));
    if (m_deliver()) chk({req, "/R5 vector"}, 32'(irq_vector), 32'(top_of(m_irr)));
    chk({req, "/R10 summary"}, summary, m_summary());
    chk({req, "/R4 ppr"}, 32'(ppr), 32'(m_ppr()));
    chk({req, "/R9 tpr"}, 32'(tpr_rdata), 32'(m_tpr));
  endtask

  // called at a falling edge; returns at a falling edge with outputs settled
  task automatic send_req(input int v, input logic lvl, input string req);
    logic exp_acc = hw_en && sw_en && !m_irr[v];
    req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
    #1;
    chk({req, " accepted"}, 32'(req_accepted), 32'(exp_acc));
    if (exp_acc) begin m_irr[v] = 1'b1; m_tmr[v] = lvl; end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_ack(input string req);
    if (m_deliver()) begin
      int t = top_of(m_irr);
      m_isr[t] = 1'b1;
      m_irr[t] = 1'b0;
    end
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    @(negedge clk);
    compare_all(req);
  endtask

  task automatic do_eoi(input string req);
    int t = top_of(m_isr);
    logic exp_p = 1'b0;
    logic [7:0] exp_v = 8'h00;
    if (t >= 0) begin
      if (m_tmr[t] && !eoi_bcast_suppress) begin exp_p = 1'b1; exp_v = 8'(t); end
      m_isr[t] = 1'b0;
      m_tmr[t] = 1'b0;
    end
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
    chk({req, "/R8 pulse"}, 32'(level_eoi_valid), 32'(exp_p));
    if (exp_p) chk({req, "/R8 vector"}, 32'(level_eoi_vector), 32'(exp_v));
    @(negedge clk);
    chk({req, "/R8 one cycle"}, 32'(level_eoi_valid), 32'(0));
    compare_all(req);
  endtask

  task automatic write_tpr(input logic [31:0] val, input string req);
    m_tpr = val[7:0];
    tpr_we = 1'b1; tpr_wdata = val;
    @(negedge clk);
    tpr_we = 1'b0;
    @(negedge clk);
    compare_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_en = 1'b1; sw_en = 1'b1; eoi_bcast_suppress = 1'b0;
    req_valid = 1'b0; req_vector = '0; req_level = 1'b0; irq_ack = 1'b0;
    tpr_we = 1'b0; tpr_wdata = '0; eoi = 1'b0;
    m_irr = '0; m_isr = '0; m_tmr = '0; m_tpr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk("R11 pending", 32'(irq_pending), 0);
    chk("R11 level eoi", 32'(level_eoi_valid), 0);
    chk("R11 summary", summary, 0);
    chk("R11 tpr", 32'(tpr_rdata), 0);

    // R1 R2 R5 R6 R7: edge sweep over every vector
    for (int v = 0; v < 256; v++) begin
      send_req(v, 1'b0, "R1 edge req");
      send_req(v, 1'b0, "R2 repeat req");
      if (m_deliver()) begin
        do_ack("R6 ack");
        do_eoi("R7 eoi edge");
      end
    end

    // R8: level sweep, suppress on every third vector
    for (int v = 16; v < 256; v++) begin
      eoi_bcast_suppress = (v % 3 == 0);
      send_req(v, 1'b1, "R1 level req");
      do_ack("R6 ack level");
      do_eoi("R8 eoi level");
    end
    eoi_bcast_suppress = 1'b0;

    // R4 R5 R9: every task priority against one pending vector
    send_req(8'h80, 1'b0, "R5 setup");
    for (int t = 0; t < 256; t++) write_tpr(32'(t) | 32'hA5A5_0000, "R9 tpr sweep");
    write_tpr(32'h1234_5600, "R9 upper bits dropped");
    do_ack("R6 ack 0x80");
    do_eoi("R7 eoi 0x80");

    // R4 R7: nesting
    send_req(8'h50, 1'b0, "R4 nest a");
    do_ack("R6 nest a");
    send_req(8'h40, 1'b0, "R5 blocked below isr");
    write_tpr(32'h57, "R4 tpr above isr class");
    write_tpr(32'h37, "R4 tpr below isr class");
    write_tpr(32'h00, "R4 tpr clear");
    send_req(8'h60, 1'b1, "R5 nest b");
    do_ack("R6 nest b");
    do_eoi("R7 highest first");
    do_eoi("R7 next");
    do_ack("R6 released");
    do_eoi("R7 last");

    // R6: acknowledge with nothing deliverable
    do_ack("R6 ignored ack");

    // R3: disabled intake
    hw_en = 1'b0;
    send_req(8'h90, 1'b0, "R3 hw off");
    hw_en = 1'b1; sw_en = 1'b0;
    send_req(8'hA0, 1'b1, "R3 sw off");
    sw_en = 1'b1;

    // R7: retire with empty in-service map
    do_eoi("R7 empty eoi");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule